// File: doc/BRIEF.md
# Interrupt Scan Dispatcher

The dispatcher holds a small pending-status register for every interrupt channel (eight interrupt ids per channel) plus a one-bit enable per channel. It finds pending work and hands it out one interrupt at a time. It does this in two steps. First it walks a bounded run of 32-bit summary words, where each summary bit stands for one channel. When it finds a word with a bit set, it loads the lowest flagged channel's status and picks that channel's lowest pending id. It then presents the result as an event. The event stays on the outputs until an acknowledge arrives. The acknowledge clears exactly that status bit, and the walk starts again from the first word of the range.

Interrupt sources are modelled as single-cycle set pulses that name a channel and an id. A per-channel identity table supplies a 4-bit slave id and an 8-bit peripheral number, and these fields are packed into the event word. Two range inputs, the lowest and highest channel of interest, limit which summary words are visited. A level interrupt output reports whether any enabled channel inside the visited words has pending status.

Top module: `arb_scan_dispatch`

## Requirements
- R1: After reset, no event is presented, `evtWord` reads zero, the interrupt output is low, and every status bit and every enable bit is cleared.
- R2: A set pulse marks status bit `setId` of channel `setChan`. The bit stays set until it is acknowledged. If a set pulse and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R3: Channel n is summarised by bit n mod 32 of summary word n / 32. A summary bit is one when the channel is enabled and at least one of its status bits is set. Inside a word, the lowest flagged channel is taken first.
- R4: A channel whose enable bit is zero is never dispatched and does not raise the interrupt output. Its pending status is kept, and it is dispatched once the channel is enabled.
- R5: Only summary words minChan / 32 through maxChan / 32 are visited. Pending channels in other words are neither dispatched nor reflected in the interrupt output. When minChan / 32 is greater than maxChan / 32, the range is empty.
- R6: Inside a channel, the lowest pending id is dispatched first. After every acknowledge the walk restarts at word minChan / 32, so a lower word keeps priority over a higher one.
- R7: While an event is presented, `evtWord` carries the slave id in bits 31:28, the peripheral number in bits 27:20, the interrupt id in bits 18:16 and the channel in bits 8:0. All other bits are zero.
- R8: A presented event holds its channel, id and word unchanged until it is acknowledged. An acknowledge given while no event is presented has no effect on any status.
- R9: Acknowledging an event clears that one status bit, like writing a one-hot mask to a write-one-to-clear register. `evtValid` is low in the cycle that follows.
- R10: `irqOut` is high exactly when some enabled channel in a visited word has a pending status bit. It follows the status registers and the range inputs without any further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setValid | input | 1 | Set pulse for one status bit |
| setChan | input | CH_W | Channel of the set pulse |
| setId | input | 3 | Interrupt id of the set pulse |
| enWrValid | input | 1 | Write strobe for one channel enable |
| enWrChan | input | CH_W | Channel whose enable is written |
| enWrVal | input | 1 | New enable value |
| idWrValid | input | 1 | Write strobe for one identity entry |
| idWrChan | input | CH_W | Channel whose identity is written |
| idWrSid | input | 4 | Slave id for that channel |
| idWrPer | input | 8 | Peripheral number for that channel |
| minChan | input | CH_W | Lowest channel of the scan range |
| maxChan | input | CH_W | Highest channel of the scan range |
| ackValid | input | 1 | Acknowledge of the presented event |
| evtValid | output | 1 | An event is presented |
| evtWord | output | 32 | Packed event identifier |
| evtChan | output | CH_W | Channel of the presented event |
| evtId | output | 3 | Interrupt id of the presented event |
| irqOut | output | 1 | Any enabled in-range status pending |

## Verification
Each status change is registered on the edge where its set pulse or acknowledge is sampled, and `irqOut` reflects it right after that edge. The event timing depends on where the walk is. If the walk is already on the target word, the channel is captured on the next edge and the event appears one edge after that, so two edges after the set pulse. Otherwise one extra edge is needed for each word still to be visited. An acknowledge drops `evtValid` on the edge that samples it, and the next event follows at least two edges later. The bench models these edge counts behaviourally and compares the outputs half a period after every edge. The scenario checks wait for an event with a bounded loop instead of a fixed delay.

// File: rtl/arb_scan_pkg.sv
package arb_scan_pkg;

  localparam int WORD_W     = 32;
  localparam int ID_W       = 3;
  localparam int NUM_IDS    = 1 << ID_W;
  localparam int SID_W      = 4;
  localparam int PER_W      = 8;
  localparam int EVT_W      = 32;
  localparam int EVT_CHAN_W = 9;

  typedef enum logic [1:0] {
    ST_SCAN = 2'd0,
    ST_READ = 2'd1,
    ST_EMIT = 2'd2
  } scanState_e;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic                  valid;
    logic [EVT_CHAN_W-1:0] chan;
    logic [ID_W-1:0]       id;
  } clrCmd_t;

  function automatic logic [4:0] lowest32(input logic [WORD_W-1:0] v);
    lowest32 = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) lowest32 = 5'(i);
    end
  endfunction

  function automatic logic [ID_W-1:0] lowestId(input logic [NUM_IDS-1:0] v);
    lowestId = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (v[i]) lowestId = ID_W'(i);
    end
  endfunction

endpackage

// File: rtl/scan_datapath.sv
module scan_datapath
  import arb_scan_pkg::*;
#(
  parameter int NUM_CHAN = 64,
  parameter int CH_W     = 6,
  parameter int WIDX_W   = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  setValid,
  input  logic [CH_W-1:0]       setChan,
  input  logic [ID_W-1:0]       setId,
  input  logic                  enWrValid,
  input  logic [CH_W-1:0]       enWrChan,
  input  logic                  enWrVal,
  input  logic                  idWrValid,
  input  logic [CH_W-1:0]       idWrChan,
  input  logic [SID_W-1:0]      idWrSid,
  input  logic [PER_W-1:0]      idWrPer,
  input  clrCmd_t               clrCmd,
  input  logic [WIDX_W-1:0]     firstWord,
  input  logic [WIDX_W-1:0]     lastWord,
  input  logic [WIDX_W-1:0]     wordSel,
  input  logic [CH_W-1:0]       chanSel,
  output logic [WORD_W-1:0]     selWord,
  output logic [NUM_IDS-1:0]    selStatus,
  output logic                  selEnable,
  output logic [SID_W-1:0]      selSid,
  output logic [PER_W-1:0]      selPer,
  output logic                  irqOut
);

  localparam int PAD_WORDS = 1 << WIDX_W;
  localparam int PAD_CHANS = PAD_WORDS * WORD_W;

  logic [NUM_CHAN-1:0][NUM_IDS-1:0] statusQ;
  logic [NUM_CHAN-1:0]              enableQ;
  logic [NUM_CHAN-1:0][SID_W-1:0]   sidQ;
  logic [NUM_CHAN-1:0][PER_W-1:0]   perQ;
  logic [PAD_WORDS-1:0][WORD_W-1:0] summary;

  // status: clear first, a set of the same bit in the same cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      sidQ    <= '0;
      perQ    <= '0;
    end else begin
      if (clrCmd.valid && (int'(clrCmd.chan) < NUM_CHAN))
        statusQ[clrCmd.chan[CH_W-1:0]][clrCmd.id] <= 1'b0;
      if (setValid && (int'(setChan) < NUM_CHAN))
        statusQ[setChan][setId] <= 1'b1;
      if (enWrValid && (int'(enWrChan) < NUM_CHAN))
        enableQ[enWrChan] <= enWrVal;
      if (idWrValid && (int'(idWrChan) < NUM_CHAN)) begin
        sidQ[idWrChan] <= idWrSid;
        perQ[idWrChan] <= idWrPer;
      end
    end
  end

  // summary bits, padded to a whole number of words
  for (genvar c = 0; c < PAD_CHANS; c++) begin : g_sum
    if (c < NUM_CHAN) begin : g_live
      assign summary[c / WORD_W][c % WORD_W] = enableQ[c] && (|statusQ[c]);
    end else begin : g_pad
      assign summary[c / WORD_W][c % WORD_W] = 1'b0;
    end
  end

  always_comb begin
    irqOut = 1'b0;
    for (int w = 0; w < PAD_WORDS; w++) begin
      if ((WIDX_W'(w) >= firstWord) && (WIDX_W'(w) <= lastWord) && (|summary[w]))
        irqOut = 1'b1;
    end
  end

  assign selWord = summary[wordSel];

  always_comb begin
    if (int'(chanSel) < NUM_CHAN) begin
      selStatus = statusQ[chanSel];
      selEnable = enableQ[chanSel];
      selSid    = sidQ[chanSel];
      selPer    = perQ[chanSel];
    end else begin
      selStatus = '0;
      selEnable = 1'b0;
      selSid    = '0;
      selPer    = '0;
    end
  end

  assert_clr_pending_R9 : assert property (@(posedge clk) disable iff (!rstN)
    clrCmd.valid |-> statusQ[clrCmd.chan[CH_W-1:0]][clrCmd.id]);

  assert_empty_range_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (firstWord > lastWord) |-> !irqOut);

endmodule

// File: rtl/scan_control.sv
module scan_control
  import arb_scan_pkg::*;
#(
  parameter int CH_W   = 6,
  parameter int WIDX_W = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackValid,
  input  logic [WIDX_W-1:0]  firstWord,
  input  logic [WIDX_W-1:0]  lastWord,
  input  logic [WORD_W-1:0]  selWord,
  input  logic [NUM_IDS-1:0] selStatus,
  input  logic               selEnable,
  output logic [WIDX_W-1:0]  wordIdx,
  output logic [CH_W-1:0]    curChan,
  output logic [ID_W-1:0]    curId,
  output logic               evtValid,
  output clrCmd_t            clrCmd
);

  localparam int FULL_W = WIDX_W + 5;

  scanState_e         st;
  logic               inRange;
  logic [FULL_W-1:0]  hitChan;
  logic [NUM_IDS-1:0] livePend;

  assign inRange  = (wordIdx >= firstWord) && (wordIdx <= lastWord);
  assign hitChan  = {wordIdx, lowest32(selWord)};
  assign livePend = selStatus & {NUM_IDS{selEnable}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_SCAN;
      wordIdx <= '0;
      curChan <= '0;
      curId   <= '0;
    end else begin
      case (st)
        ST_SCAN: begin
          if (!inRange) begin
            wordIdx <= firstWord;
          end else if (selWord != '0) begin
            curChan <= hitChan[CH_W-1:0];
            st      <= ST_READ;
          end else begin
            wordIdx <= (wordIdx >= lastWord) ? firstWord : wordIdx + 1'b1;
          end
        end
        ST_READ: begin
          if (livePend != '0) begin
            curId <= lowestId(livePend);
            st    <= ST_EMIT;
          end else begin
            st      <= ST_SCAN;
            wordIdx <= firstWord;
          end
        end
        ST_EMIT: begin
          if (ackValid) begin
            st      <= ST_SCAN;
            wordIdx <= firstWord;
          end
        end
        default: st <= ST_SCAN;
      endcase
    end
  end

  assign evtValid     = (st == ST_EMIT);
  assign clrCmd.valid = evtValid && ackValid;
  assign clrCmd.chan  = EVT_CHAN_W'(curChan);
  assign clrCmd.id    = curId;

  assert_evt_hold_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !ackValid) |=> (evtValid && $stable(curChan) && $stable(curId)));

  assert_ack_release_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && ackValid) |=> !evtValid);

  assert_evt_pending_R2 : assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> selStatus[curId]);

endmodule

// File: rtl/arb_scan_dispatch.sv
module arb_scan_dispatch
  import arb_scan_pkg::*;
#(
  parameter  int NUM_CHAN = 64,
  localparam int CH_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [CH_W-1:0]   setChan,
  input  logic [2:0]        setId,
  input  logic              enWrValid,
  input  logic [CH_W-1:0]   enWrChan,
  input  logic              enWrVal,
  input  logic              idWrValid,
  input  logic [CH_W-1:0]   idWrChan,
  input  logic [3:0]        idWrSid,
  input  logic [7:0]        idWrPer,
  input  logic [CH_W-1:0]   minChan,
  input  logic [CH_W-1:0]   maxChan,
  input  logic              ackValid,
  output logic              evtValid,
  output logic [31:0]       evtWord,
  output logic [CH_W-1:0]   evtChan,
  output logic [2:0]        evtId,
  output logic              irqOut
);

  localparam int WIDX_W = (CH_W > 5) ? CH_W - 5 : 1;

  logic [WIDX_W-1:0]  firstWord, lastWord, wordIdx;
  logic [WORD_W-1:0]  selWord;
  logic [NUM_IDS-1:0] selStatus;
  logic               selEnable;
  logic [SID_W-1:0]   selSid;
  logic [PER_W-1:0]   selPer;
  clrCmd_t            clrCmd;

  assign firstWord = WIDX_W'(minChan >> 5);
  assign lastWord  = WIDX_W'(maxChan >> 5);

  scan_datapath #(.NUM_CHAN(NUM_CHAN), .CH_W(CH_W), .WIDX_W(WIDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setChan(setChan), .setId(setId),
    .enWrValid(enWrValid), .enWrChan(enWrChan), .enWrVal(enWrVal),
    .idWrValid(idWrValid), .idWrChan(idWrChan), .idWrSid(idWrSid), .idWrPer(idWrPer),
    .clrCmd(clrCmd), .firstWord(firstWord), .lastWord(lastWord),
    .wordSel(wordIdx), .chanSel(evtChan),
    .selWord(selWord), .selStatus(selStatus), .selEnable(selEnable),
    .selSid(selSid), .selPer(selPer), .irqOut(irqOut)
  );

  scan_control #(.CH_W(CH_W), .WIDX_W(WIDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .ackValid(ackValid),
    .firstWord(firstWord), .lastWord(lastWord),
    .selWord(selWord), .selStatus(selStatus), .selEnable(selEnable),
    .wordIdx(wordIdx), .curChan(evtChan), .curId(evtId),
    .evtValid(evtValid), .clrCmd(clrCmd)
  );

  assign evtWord = evtValid ? {selSid, selPer, 1'b0, evtId, 7'b0, EVT_CHAN_W'(evtChan)} : '0;

endmodule

// File: tb/tb_arb_scan_dispatch.sv
module tb_arb_scan_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 64;
  localparam int CW   = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic setValid = 0, enWrValid = 0, enWrVal = 0, idWrValid = 0, ackValid = 0;
  logic [CW-1:0] setChan = '0, enWrChan = '0, idWrChan = '0;
  logic [CW-1:0] minChan = '0, maxChan = 6'd63;
  logic [2:0] setId = '0;
  logic [3:0] idWrSid = '0;
  logic [7:0] idWrPer = '0;
  logic evtValid, irqOut;
  logic [31:0] evtWord;
  logic [CW-1:0] evtChan;
  logic [2:0] evtId;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit started = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arb_scan_dispatch #(.NUM_CHAN(NCH)) dut (
    .clk(clk), .rstN(rstN), .setValid(setValid), .setChan(setChan), .setId(setId),
    .enWrValid(enWrValid), .enWrChan(enWrChan), .enWrVal(enWrVal),
    .idWrValid(idWrValid), .idWrChan(idWrChan), .idWrSid(idWrSid), .idWrPer(idWrPer),
    .minChan(minChan), .maxChan(maxChan), .ackValid(ackValid),
    .evtValid(evtValid), .evtWord(evtWord), .evtChan(evtChan), .evtId(evtId), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [7:0] mStat [NCH];
  bit         mEn   [NCH];
  logic [3:0] mSid  [NCH];
  logic [7:0] mPer  [NCH];
  int mState = 0, mWord = 0, mChan = 0, mId = 0;

  always @(posedge clk) begin
    int first, last, hit, cc, ci;
    bit doClr;
    logic [7:0] v;
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mStat[c] = 0; mEn[c] = 0; mSid[c] = 0; mPer[c] = 0;
      end
      mState = 0; mWord = 0; mChan = 0; mId = 0;
    end else begin
      first = int'(minChan) / 32;
      last  = int'(maxChan) / 32;
      doClr = 0; cc = 0; ci = 0;
      if (mState == 0) begin
        if (mWord < first || mWord > last) mWord = first;
        else begin
          hit = -1;
          for (int b = 0; b < 32; b++) begin
            int c;
            c = mWord * 32 + b;
            if (hit < 0 && c < NCH && mEn[c] && mStat[c] != 0) hit = c;
          end
          if (hit >= 0) begin mChan = hit; mState = 1; end
          else mWord = (mWord >= last) ? first : mWord + 1;
        end
      end else if (mState == 1) begin
        v = mEn[mChan] ? mStat[mChan] : 8'h0;
        if (v != 0) begin
          for (int i = 7; i >= 0; i--) if (v[i]) mId = i;
          mState = 2;
        end else begin mState = 0; mWord = first; end
      end else begin
        if (ackValid) begin doClr = 1; cc = mChan; ci = mId; mState = 0; mWord = first; end
      end
      if (doClr) mStat[cc][ci] = 1'b0;
      if (setValid) mStat[setChan][setId] = 1'b1;
      if (enWrValid) mEn[enWrChan] = enWrVal;
      if (idWrValid) begin mSid[idWrChan] = idWrSid; mPer[idWrChan] = idWrPer; end
    end
  end

  function automatic bit modelIrq();
    bit r = 0;
    for (int c = 0; c < NCH; c++)
      if (c / 32 >= int'(minChan) / 32 && c / 32 <= int'(maxChan) / 32 && mEn[c] && mStat[c] != 0)
        r = 1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    cycles++;
    if (started && rstN) begin
      logic [31:0] expWord;
      chk(evtValid == (mState == 2), "R8", "evtValid vs model", 32'(evtValid), 32'(mState == 2));
      if (mState == 2) begin
        chk(evtChan == CW'(mChan) && evtId == 3'(mId), "R6", "event chan/id vs model",
            {evtChan, evtId}, {CW'(mChan), 3'(mId)});
        expWord = {mSid[mChan], mPer[mChan], 1'b0, 3'(mId), 7'b0, 9'(mChan)};
        chk(evtWord == expWord, "R7", "evtWord vs model", evtWord, expWord);
      end
      chk(irqOut == modelIrq(), "R10", "irqOut vs model", 32'(irqOut), 32'(modelIrq()));
    end
    if (cycles >= 150000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic setBit(input int ch, input int id);
    setValid = 1; setChan = CW'(ch); setId = 3'(id); @(negedge clk); setValid = 0;
  endtask
  task automatic enable(input int ch, input bit v);
    enWrValid = 1; enWrChan = CW'(ch); enWrVal = v; @(negedge clk); enWrValid = 0;
  endtask
  task automatic ident(input int ch, input int sid, input int per);
    idWrValid = 1; idWrChan = CW'(ch); idWrSid = 4'(sid); idWrPer = 8'(per);
    @(negedge clk); idWrValid = 0;
  endtask
  task automatic ack();
    ackValid = 1; @(negedge clk); ackValid = 0;
  endtask
  task automatic range(input int lo, input int hi);
    minChan = CW'(lo); maxChan = CW'(hi);
  endtask
  task automatic waitEvt(input int ch, input int id, input string req);
    for (int k = 0; k < 100 && !evtValid; k++) @(negedge clk);
    chk(evtValid, req, "event presented", 32'(evtValid), 32'd1);
    chk(evtChan == CW'(ch) && evtId == 3'(id), req, "event chan/id",
        {evtChan, evtId}, {CW'(ch), 3'(id)});
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    @(negedge clk);
    started = 1;
    // R1 reset state
    chk(!evtValid, "R1", "evtValid after reset", 32'(evtValid), 0);
    chk(!irqOut, "R1", "irqOut after reset", 32'(irqOut), 0);
    chk(evtWord == 0, "R1", "evtWord after reset", evtWord, 0);
    range(0, 63);

    // R4 disabled channel is held back, then dispatched when enabled
    ident(5, 4'hA, 8'h5C);
    setBit(5, 3);
    cyc(10);
    chk(!irqOut, "R4", "irq with channel disabled", 32'(irqOut), 0);
    chk(!evtValid, "R4", "no event with channel disabled", 32'(evtValid), 0);
    enable(5, 1);
    chk(irqOut, "R10", "irq right after enable", 32'(irqOut), 1);
    waitEvt(5, 3, "R4");
    chk(evtWord == 32'hA5C3_0005, "R7", "packed event word", evtWord, 32'hA5C3_0005);

    // R8 hold, R9 clear on acknowledge
    cyc(4);
    chk(evtValid && evtChan == 5 && evtId == 3, "R8", "event held", {evtChan, evtId}, {6'd5, 3'd3});
    ack();
    chk(!evtValid, "R9", "event drops after ack", 32'(evtValid), 0);
    chk(!irqOut, "R9", "status cleared by ack", 32'(irqOut), 0);

    // R6 lowest id first
    setBit(7, 6); setBit(7, 2); setBit(7, 4);
    enable(7, 1);
    waitEvt(7, 2, "R6"); ack();
    waitEvt(7, 4, "R6"); ack();
    waitEvt(7, 6, "R6"); ack();

    // R5 empty range, then R3 lowest channel in a word, R6 restart priority
    range(32, 0);
    enable(40, 1); enable(33, 1);
    setBit(40, 1); setBit(33, 0);
    cyc(3);
    chk(!irqOut, "R5", "irq with empty range", 32'(irqOut), 0);
    chk(!evtValid, "R5", "no event with empty range", 32'(evtValid), 0);
    range(0, 63);
    waitEvt(33, 0, "R3");
    enable(2, 1);
    setBit(2, 5);
    ack();
    waitEvt(2, 5, "R6");
    ack();
    waitEvt(40, 1, "R3");
    ack();

    // R5 word outside range ignored
    range(32, 63);
    enable(3, 1);
    setBit(3, 1);
    cyc(8);
    chk(!irqOut, "R5", "out-of-range irq", 32'(irqOut), 0);
    chk(!evtValid, "R5", "out-of-range event", 32'(evtValid), 0);
    range(0, 63);
    waitEvt(3, 1, "R5");
    ack();

    // R3 top channel sits in word 1 bit 31
    range(63, 63);
    ident(63, 4'hF, 8'hFF);
    enable(63, 1);
    setBit(63, 7);
    waitEvt(63, 7, "R3");
    chk(evtWord == 32'hFFF7_003F, "R7", "packed word for channel 63", evtWord, 32'hFFF7_003F);
    ack();
    range(0, 63);

    // R8 acknowledge with no event leaves status alone
    setBit(9, 2);
    cyc(2);
    ack();
    enable(9, 1);
    waitEvt(9, 2, "R8");
    ack();

    // R2 set and acknowledge of the same bit in one cycle
    enable(11, 1);
    setBit(11, 4);
    waitEvt(11, 4, "R2");
    ackValid = 1; setValid = 1; setChan = 6'd11; setId = 3'd4;
    @(negedge clk);
    ackValid = 0; setValid = 0;
    chk(!evtValid, "R9", "event drops after ack", 32'(evtValid), 0);
    chk(irqOut, "R2", "set wins over clear", 32'(irqOut), 1);
    waitEvt(11, 4, "R2");
    ack();

    cyc(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule